// File: doc/BRIEF.md
# Serial Word Assembler with Inter-Word Gap Qualification

This block turns a stream of qualified serial bits into 32-bit words. A bit sampler upstream delivers one strobe per accepted data bit, along with the bit value. It also raises an error pulse when the timing of a bit is out of tolerance, and reports whether the upper and lower sections of its sampling register currently each show a run of three null samples. The assembler shifts the accepted bits in, least significant first. It counts them, and after the thirty-second bit it latches the finished word and raises a single-cycle end-of-sequence pulse. Before latching, it replaces the most significant bit with the outcome of a parity check taken over all 32 received bits.

Words are only accepted while the reception-enable output is high. After reset, after every completed word and after any mid-word timing error, reception is disarmed. A gap timer then counts sample ticks and tests the null indicator at a fixed spacing: every 10 ticks at the fast rate and every 80 ticks at the slow rate. Three passing tests in a row re-arm reception. A failing test discards the progress made so far. The speed select is a plain input. Line sampling and host readout sit outside this block.

Top module: `word_assembler`

## Requirements
- R1: When the 32nd accepted bit strobe of a word arrives, `eosPulse` is high for exactly one cycle, in the cycle after that strobe, and `wordOut` holds the new word in that same cycle. No pulse occurs before the 32nd bit.
- R2: The first accepted bit of a word lands in `wordOut[0]`, and the n-th bit lands in `wordOut[n-1]` for n from 1 to 31.
- R3: `wordOut[31]` is 0 when the number of ones among all 32 received bits, the 32nd bit included, is odd. It is 1 when that number is even.
- R4: With `speedLow` = 0 the gap timer tests the null indicator on every 10th sample tick. Starting from a freshly disarmed state with qualified nulls held, `rxEnable` rises in the cycle after the 30th tick and not earlier.
- R5: With `speedLow` = 1 the test spacing is 80 sample ticks, so `rxEnable` rises after the 240th tick and not earlier.
- R6: A test passes only when `nullUpper` and `nullLower` are both 1 at the tick of the test. Three passing tests in a row set `rxEnable` to 1.
- R7: A failing test clears the count of passing tests and restarts the spacing, so that three further passing tests, 30 ticks at the fast rate, are needed.
- R8: A `bitError` pulse while `rxEnable` is 1 discards the partial word. `rxEnable` drops in the next cycle, no `eosPulse` occurs, `wordOut` keeps its previous value, and the next word needs a new gap.
- R9: After reset `rxEnable`, `eosPulse` and `wordOut` are 0. Bit strobes received while `rxEnable` is 0 are ignored and do not advance the bit count.
- R10: `rxEnable` is 0 in the cycle in which `eosPulse` is high, and the next word is accepted only after a new qualified gap.
- R11: Cycles with `sampleTick` = 0 do not advance the gap timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedLow | input | 1 | 1 selects the 80-tick gap spacing, 0 the 10-tick spacing |
| sampleTick | input | 1 | One-cycle strobe for each sample clock |
| bitStrobe | input | 1 | An accepted data bit is present on bitValue |
| bitValue | input | 1 | Value of the accepted data bit |
| bitError | input | 1 | Bit timing error from the sampler |
| nullUpper | input | 1 | Upper sampling section shows three consecutive nulls |
| nullLower | input | 1 | Lower sampling section shows three consecutive nulls |
| wordOut | output | 32 | Last completed word, with bit 31 replaced by the parity result |
| eosPulse | output | 1 | One-cycle end-of-sequence pulse |
| rxEnable | output | 1 | Reception armed; bits are accepted only while high |

## Verification
On every cycle the assertions check the following. The end-of-sequence pulse never lasts two cycles. The output word only changes together with that pulse. Any rise of the enable is preceded by a ticked, doubly qualified null. Both a timing error and a completed word disarm reception, the pass count stays below its limit, and the gap timer holds still on cycles without a tick. Only the bench scenarios can show that the right bits are assembled in the right order with the right parity value, and that the enable rises after exactly 30 or 240 ticks. The same scenarios show that a failed test restarts the whole count, that single-section nulls never qualify, and that bits sent while disarmed leave the next word's bit count untouched.

// File: rtl/wordasm_pkg.sv
package wordasm_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic shiftEn;    // shift an accepted bit in
    logic clearBits;  // drop the partial word
    logic latchWord;  // this shift completes the word
  } asmStrobes_t;

  typedef enum logic {
    ST_GAP  = 1'b0,
    ST_RECV = 1'b1
  } asmState_t;

endpackage

// File: rtl/wordasm_ctrl.sv
module wordasm_ctrl
  import wordasm_pkg::*;
#(
  parameter int HI_INTERVAL = 10,
  parameter int LO_INTERVAL = 80,
  parameter int GAP_CHECKS  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        speedLow,
  input  logic        sampleTick,
  input  logic        bitStrobe,
  input  logic        bitError,
  input  logic        nullUpper,
  input  logic        nullLower,
  input  logic        lastBit,
  output asmStrobes_t strobes,
  output logic        rxEnable
);

  localparam int MAX_IV = (LO_INTERVAL > HI_INTERVAL) ? LO_INTERVAL : HI_INTERVAL;
  localparam int TW     = $clog2(MAX_IV + 1);
  localparam int GW     = $clog2(GAP_CHECKS + 1);

  asmState_t      state;
  logic [TW-1:0]  gapTimer;
  logic [GW-1:0]  gapCount;
  logic [TW-1:0]  interval;
  logic           gapNull;
  logic           checkNow;

  always_comb begin
    gapNull  = nullUpper & nullLower;
    interval = speedLow ? TW'(LO_INTERVAL) : TW'(HI_INTERVAL);
    checkNow = (state == ST_GAP) && sampleTick && (gapTimer >= interval - TW'(1));
  end

  // Strobes toward the datapath; an error wins over a coincident bit
  always_comb begin
    strobes = '0;
    if (state == ST_RECV) begin
      if (bitError) begin
        strobes.clearBits = 1'b1;
      end else if (bitStrobe) begin
        strobes.shiftEn   = 1'b1;
        strobes.latchWord = lastBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_GAP;
      gapTimer <= '0;
      gapCount <= '0;
    end else begin
      case (state)
        ST_GAP: begin
          if (sampleTick) begin
            if (checkNow) begin
              gapTimer <= '0;
              if (gapNull) begin
                if (gapCount == GW'(GAP_CHECKS - 1)) begin
                  gapCount <= '0;
                  state    <= ST_RECV;
                end else begin
                  gapCount <= gapCount + GW'(1);
                end
              end else begin
                gapCount <= '0;
              end
            end else begin
              gapTimer <= gapTimer + TW'(1);
            end
          end
        end
        ST_RECV: begin
          if (strobes.clearBits || strobes.latchWord) begin
            state    <= ST_GAP;
            gapTimer <= '0;
            gapCount <= '0;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  assign rxEnable = (state == ST_RECV);

  AST_GAPCOUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    gapCount < GW'(GAP_CHECKS)); // R6
  AST_ARM_NEEDS_NULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> $past(nullUpper && nullLower && sampleTick)); // R6
  AST_ERROR_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && bitError) |=> !rxEnable); // R8
  AST_LATCH_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchWord |=> !rxEnable); // R10
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !rxEnable) |=> $stable(gapTimer)); // R11
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    gapTimer < TW'(MAX_IV)); // R5

endmodule

// File: rtl/wordasm_datapath.sv
module wordasm_datapath
  import wordasm_pkg::*;
#(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  asmStrobes_t          strobes,
  input  logic                 bitValue,
  output logic                 lastBit,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 eosPulse
);

  localparam int CW = $clog2(WORD_BITS);

  // Holds the upper WORD_BITS-1 positions; the final bit completes the word
  logic [WORD_BITS-2:0] shiftReg;
  logic [WORD_BITS-1:0] nextShift;
  logic [CW-1:0]        bitCount;
  logic                 onesOdd;

  always_comb begin
    nextShift = {bitValue, shiftReg};
    onesOdd   = ^nextShift;
    lastBit   = (bitCount == CW'(WORD_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCount <= '0;
      wordOut  <= '0;
      eosPulse <= 1'b0;
    end else begin
      eosPulse <= strobes.latchWord;
      if (strobes.clearBits) begin
        bitCount <= '0;
      end else if (strobes.shiftEn) begin
        shiftReg <= nextShift[WORD_BITS-1:1];
        bitCount <= lastBit ? '0 : bitCount + CW'(1);
      end
      if (strobes.latchWord) begin
        wordOut <= {~onesOdd, nextShift[WORD_BITS-2:0]};
      end
    end
  end

  AST_EOS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    eosPulse |=> !eosPulse); // R1
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !eosPulse |-> $stable(wordOut)); // R8

endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import wordasm_pkg::*;
#(
  parameter int WORD_BITS   = 32,
  parameter int HI_INTERVAL = 10,
  parameter int LO_INTERVAL = 80,
  parameter int GAP_CHECKS  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 speedLow,
  input  logic                 sampleTick,
  input  logic                 bitStrobe,
  input  logic                 bitValue,
  input  logic                 bitError,
  input  logic                 nullUpper,
  input  logic                 nullLower,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 eosPulse,
  output logic                 rxEnable
);

  asmStrobes_t strobes;
  logic        lastBit;

  wordasm_ctrl #(
    .HI_INTERVAL (HI_INTERVAL),
    .LO_INTERVAL (LO_INTERVAL),
    .GAP_CHECKS  (GAP_CHECKS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .speedLow   (speedLow),
    .sampleTick (sampleTick),
    .bitStrobe  (bitStrobe),
    .bitError   (bitError),
    .nullUpper  (nullUpper),
    .nullLower  (nullLower),
    .lastBit    (lastBit),
    .strobes    (strobes),
    .rxEnable   (rxEnable)
  );

  wordasm_datapath #(
    .WORD_BITS (WORD_BITS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bitValue (bitValue),
    .lastBit  (lastBit),
    .wordOut  (wordOut),
    .eosPulse (eosPulse)
  );

  AST_SHIFT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |-> rxEnable); // R9
  AST_EOS_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    eosPulse |-> !rxEnable); // R10

endmodule

// File: tb/word_assembler_tb.sv
`timescale 1ns/1ps
module word_assembler_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        speedLow = 1'b0;
  logic        sampleTick = 1'b0;
  logic        bitStrobe = 1'b0;
  logic        bitValue = 1'b0;
  logic        bitError = 1'b0;
  logic        nullUpper = 1'b0;
  logic        nullLower = 1'b0;
  logic [31:0] wordOut;
  logic        eosPulse;
  logic        rxEnable;

  int checks = 0;
  int errors = 0;
  int earlyEos = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  word_assembler u_dut (
    .clk(clk), .rstN(rstN), .speedLow(speedLow), .sampleTick(sampleTick),
    .bitStrobe(bitStrobe), .bitValue(bitValue), .bitError(bitError),
    .nullUpper(nullUpper), .nullLower(nullLower),
    .wordOut(wordOut), .eosPulse(eosPulse), .rxEnable(rxEnable)
  );

  function automatic logic [31:0] expWord(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    r[31] = ($countones(w) % 2 == 1) ? 1'b0 : 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs set before this are consumed at the next edge; outputs read after it
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic gapTicks(input int n, input logic up, input logic lo, input int maxIdle);
    for (int i = 0; i < n; i++) begin
      if (maxIdle > 0) begin
        int idle = $urandom_range(maxIdle, 0);
        for (int k = 0; k < idle; k++) cyc();
      end
      sampleTick = 1'b1; nullUpper = up; nullLower = lo;
      cyc();
      sampleTick = 1'b0;
    end
  endtask

  task automatic sendBit(input logic b);
    bitStrobe = 1'b1; bitValue = b;
    cyc();
    bitStrobe = 1'b0;
  endtask

  // Arm from a freshly disarmed state and check the exact tick of arming
  task automatic arm(input logic slow, input int maxIdle, input string req);
    int span = slow ? 240 : 30;
    speedLow = slow;
    gapTicks(span - 1, 1'b1, 1'b1, maxIdle);
    check({req, " not armed before last gap test"}, rxEnable, 0);
    gapTicks(1, 1'b1, 1'b1, maxIdle);
    check({req, " armed after last gap test"}, rxEnable, 1);
    nullUpper = 1'b0; nullLower = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w, input int maxIdle);
    earlyEos = 0;
    for (int i = 0; i < 32; i++) begin
      if (maxIdle > 0) begin
        int idle = $urandom_range(maxIdle, 0);
        for (int k = 0; k < idle; k++) begin
          cyc();
          if (eosPulse) earlyEos++;
        end
      end
      sendBit(w[i]);
      if (i < 31 && eosPulse) earlyEos++;
    end
    check("R1 eos after 32nd bit", eosPulse, 1);
    check("R2 R3 assembled word", wordOut, expWord(w));
    check("R10 disarmed with eos", rxEnable, 0);
    check("R1 no early eos", earlyEos, 0);
    cyc();
    check("R1 eos lasts one cycle", eosPulse, 0);
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) cyc();
    // R9 reset state
    check("R9 reset rxEnable", rxEnable, 0);
    check("R9 reset eos", eosPulse, 0);
    check("R9 reset word", wordOut, 0);
    rstN = 1'b1;
    cyc();

    // R9 bits while disarmed are ignored
    earlyEos = 0;
    for (int i = 0; i < 40; i++) begin
      sendBit(1'b1);
      if (eosPulse) earlyEos++;
    end
    check("R9 no eos while disarmed", earlyEos, 0);
    check("R9 word untouched while disarmed", wordOut, 0);

    // R4 R6 fast arming, then directed words (R2 R3)
    arm(1'b0, 0, "R4");
    sendWord(32'h0000_0001, 0);
    arm(1'b0, 0, "R4");
    sendWord(32'h8000_0000, 0);
    arm(1'b0, 0, "R6");
    sendWord(32'hA5A5_0F0E, 0);

    // R10 bits after a word are ignored until a new gap
    for (int i = 0; i < 20; i++) sendBit(1'b0);
    check("R10 still disarmed after word", rxEnable, 0);
    arm(1'b0, 0, "R10");
    sendWord(32'h1234_5678, 0);

    // R6 one section alone never qualifies
    gapTicks(40, 1'b1, 1'b0, 0);
    check("R6 upper null only", rxEnable, 0);
    gapTicks(40, 1'b0, 1'b1, 0);
    check("R6 lower null only", rxEnable, 0);

    // R7 failing third test restarts the count
    gapTicks(25, 1'b1, 1'b1, 0);
    gapTicks(5, 1'b0, 1'b0, 0);
    check("R7 failed test keeps disarmed", rxEnable, 0);
    arm(1'b0, 0, "R7");

    // R8 error mid-word
    held = wordOut;
    for (int i = 0; i < 10; i++) sendBit(1'b1);
    bitError = 1'b1;
    cyc();
    bitError = 1'b0;
    check("R8 error disarms", rxEnable, 0);
    check("R8 no eos on error", eosPulse, 0);
    check("R8 word kept", wordOut, held);
    for (int i = 0; i < 22; i++) sendBit(1'b1);
    check("R8 partial word not completed", eosPulse, 0);
    arm(1'b0, 0, "R8");
    sendWord(32'hDEAD_BEEF, 0);

    // R11 idle cycles between ticks do not advance the timer
    arm(1'b0, 3, "R11");
    sendWord(32'h0F0F_F0F0, 2);

    // R5 slow spacing
    arm(1'b1, 0, "R5");
    sendWord(32'h7FFF_FFFF, 0);
    speedLow = 1'b0;

    // Randomised words with random bit spacing
    for (int n = 0; n < 24; n++) begin
      logic [31:0] w = $urandom();
      arm(1'b0, (n % 3), "R4");
      sendWord(w, (n % 4));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule